// File: doc/BRIEF.md
# ADC Threshold-Compare Interrupt Gate

This block is the digital side of an 8-bit sampling converter. Software programs it through a small register bus. One register turns conversion on, one picks one of eight analog inputs, and two more hold a threshold and a compare mode. While conversion is on, a sequencer issues a one-cycle start request to the converter. It hands the converter a channel number that is captured at that start. It then waits for the converter's done strobe and its 8-bit sample, stores the sample in a read-only result register, and starts again.

The end-of-conversion interrupt can be set to fire on every sample. It can instead be gated by an unsigned magnitude test of the new sample against the threshold, and the direction of that test is selectable: at-or-above, or below. The test is made once per conversion, on the sample just stored. A result that software has not collected is simply replaced by the next one.

The sequencer has three states:
- ST_IDLE: nothing pending.
- ST_LAUNCH: start request asserted for one cycle.
- ST_BUSY: waiting for the done strobe.

Its transitions are:
- IDLE→LAUNCH: conversion enabled.
- LAUNCH→BUSY: always.
- BUSY→LAUNCH: done strobe while still enabled.
- BUSY→IDLE: done strobe after the enable has been cleared.

Top module: `adc_cmp_gate`

## Requirements
- R1: No start request (`conv_start`) is issued while the run bit (bit 7 of the control register at address 0) is 0 and no conversion is in progress. Each start request is a single-cycle pulse.
- R2: When the compare-enable bit (bit 7 of the compare register at address 4) is 0, `irq` is high for exactly one cycle, the cycle after each accepted done strobe.
- R3: When compare is enabled and the direction bit (bit 6 of address 4) is 0, `irq` pulses after a conversion only when sample ≥ threshold (address 3), compared unsigned. Otherwise it stays low.
- R4: When compare is enabled and the direction bit is 1, `irq` pulses only when sample < threshold, compared unsigned.
- R5: The result register (address 2) takes the new sample in the same cycle that `irq` would pulse. Every completed conversion overwrites it, whether or not it was read.
- R6: Clearing the run bit lets a conversion already in progress finish and store its result. After that no further start request is issued, and the result register keeps its value.
- R7: A done strobe that does not follow a start request is ignored: the result does not change and `irq` stays low.
- R8: `conv_chan` is loaded from the channel register (bits 2:0 of address 1) when each start request is issued, and is held until the next one. A channel written during a conversion applies to the next conversion.
- R9: Register map:
  - Address 0: control, bit 7 is the run bit.
  - Address 1: channel, bits 2:0.
  - Address 2: result, read-only; writes are ignored.
  - Address 3: threshold, all 8 bits.
  - Address 4: compare register, bit 7 is compare-enable and bit 6 is direction.
  
  Unimplemented bits and addresses read 0. All registers reset to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_waddr | input | 3 | Write address |
| bus_wdata | input | 8 | Write data |
| bus_raddr | input | 3 | Read address |
| bus_rdata | output | 8 | Read data (combinational from read address) |
| conv_start | output | 1 | One-cycle start request to the converter |
| conv_chan | output | 3 | Channel for the current conversion |
| conv_done | input | 1 | Converter done strobe |
| conv_data | input | 8 | Converter sample, valid with the done strobe |
| irq | output | 1 | End-of-conversion interrupt pulse |

## Verification
A sequencer stuck in ST_BUSY shows as a missing start request, about one conversion time after the expected one. A sequencer that leaves ST_BUSY without a strobe shows as a premature or doubled start, within a cycle. A wrong compare direction or a signed compare appears as a missing or extra `irq` on the cycle after the done strobe. Samples 0x7F, 0x80, 0x00 and 0xFF against threshold 0x80 expose such faults immediately. A channel latched at the wrong moment shows on `conv_chan` at the next start, and a result register that loads outside a conversion is visible on the very next read of address 2.

// File: rtl/adc_cmp_pkg.sv
package adc_cmp_pkg;
    localparam int DATA_W = 8;
    localparam int CHAN_W = 3;
    localparam int ADDR_W = 3;
    localparam int NREG   = 5;

    localparam int A_CTRL   = 0;
    localparam int A_CHAN   = 1;
    localparam int A_RESULT = 2;
    localparam int A_THR    = 3;
    localparam int A_CMP    = 4;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_BUSY   = 2'd2
    } seq_state_t;

    function automatic logic [DATA_W-1:0] field_mask(input int idx);
        logic [DATA_W-1:0] m;
        m = '0;
        case (idx)
            A_CTRL:  m[DATA_W-1] = 1'b1;
            A_CHAN:  m[CHAN_W-1:0] = '1;
            A_CMP:   m[DATA_W-1 -: 2] = 2'b11;
            default: m = '1;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/adc_cmp_regs.sv
module adc_cmp_regs
    import adc_cmp_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CHAN_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata,
    input  logic          result_load,
    input  logic [DW-1:0] result_in,
    output logic          run_en,
    output logic [CW-1:0] chan_sel,
    output logic [DW-1:0] threshold,
    output logic          cmp_en,
    output logic          cmp_dir,
    output logic [DW-1:0] result
);
    logic [DW-1:0] reg_view [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic [DW-1:0] q;
        if (i == A_RESULT) begin : g_ro
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)           q <= '0;
                else if (result_load) q <= result_in;
            end
        end else begin : g_rw
            localparam logic [DW-1:0] MASK = field_mask(i);
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    q <= '0;
                else if (wr_en && (waddr == AW'(i)))
                    q <= wdata & MASK;
            end
        end
        assign reg_view[i] = q;
    end

    always_comb begin
        rdata = '0;
        if (int'(raddr) < NREG)
            rdata = reg_view[raddr];
    end

    assign run_en    = reg_view[A_CTRL][DW-1];
    assign chan_sel  = reg_view[A_CHAN][CW-1:0];
    assign threshold = reg_view[A_THR];
    assign cmp_en    = reg_view[A_CMP][DW-1];
    assign cmp_dir   = reg_view[A_CMP][DW-2];
    assign result    = reg_view[A_RESULT];

    assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !result_load |=> $stable(result));

    assert_result_ro_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && waddr == AW'(A_RESULT) && !result_load) |=> $stable(result));
endmodule

// File: rtl/adc_cmp_seq.sv
module adc_cmp_seq
    import adc_cmp_pkg::*;
#(
    parameter int CW = CHAN_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_en,
    input  logic [CW-1:0] chan_sel,
    input  logic          conv_done,
    output logic          conv_start,
    output logic [CW-1:0] conv_chan,
    output logic          capture
);
    seq_state_t state, next_state;

    always_comb begin
        next_state = state;
        unique case (state)
            ST_IDLE:   if (run_en) next_state = ST_LAUNCH;
            ST_LAUNCH: next_state = ST_BUSY;
            ST_BUSY:   if (conv_done) next_state = run_en ? ST_LAUNCH : ST_IDLE;
            default:   next_state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= next_state;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            conv_chan <= '0;
        else if (next_state == ST_LAUNCH)
            conv_chan <= chan_sel;
    end

    assign conv_start = (state == ST_LAUNCH);
    assign capture    = (state == ST_BUSY) && conv_done;

    assert_no_start_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && state == ST_IDLE) |=> !conv_start);

    assert_start_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    assert_chan_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY && !conv_done) |=> $stable(conv_chan));

    assert_stop_after_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && !run_en) |=> (state == ST_IDLE));
endmodule

// File: rtl/adc_cmp_judge.sv
module adc_cmp_judge
    import adc_cmp_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic [DW-1:0] sample,
    input  logic [DW-1:0] threshold,
    input  logic          cmp_en,
    input  logic          cmp_dir,
    output logic          irq
);
    logic at_or_above;
    logic fire;

    always_comb begin
        at_or_above = (sample >= threshold);
        if (!cmp_en)      fire = 1'b1;
        else if (cmp_dir) fire = !at_or_above;
        else              fire = at_or_above;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= capture && fire;
    end

    assert_irq_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(capture));

    assert_irq_always_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && !cmp_en) |=> irq);

    assert_ge_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && cmp_en && !cmp_dir && sample < threshold) |=> !irq);

    assert_lt_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && cmp_en && cmp_dir && sample >= threshold) |=> !irq);
endmodule

// File: rtl/adc_cmp_gate.sv
module adc_cmp_gate
    import adc_cmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_waddr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [ADDR_W-1:0] bus_raddr,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              conv_start,
    output logic [CHAN_W-1:0] conv_chan,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    output logic              irq
);
    logic              run_en;
    logic [CHAN_W-1:0] chan_sel;
    logic [DATA_W-1:0] threshold;
    logic              cmp_en;
    logic              cmp_dir;
    logic [DATA_W-1:0] result;
    logic              capture;

    adc_cmp_regs #(.DW(DATA_W), .CW(CHAN_W), .AW(ADDR_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (bus_we),
        .waddr       (bus_waddr),
        .wdata       (bus_wdata),
        .raddr       (bus_raddr),
        .rdata       (bus_rdata),
        .result_load (capture),
        .result_in   (conv_data),
        .run_en      (run_en),
        .chan_sel    (chan_sel),
        .threshold   (threshold),
        .cmp_en      (cmp_en),
        .cmp_dir     (cmp_dir),
        .result      (result)
    );

    adc_cmp_seq #(.CW(CHAN_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_en     (run_en),
        .chan_sel   (chan_sel),
        .conv_done  (conv_done),
        .conv_start (conv_start),
        .conv_chan  (conv_chan),
        .capture    (capture)
    );

    adc_cmp_judge #(.DW(DATA_W)) u_judge (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (capture),
        .sample    (conv_data),
        .threshold (threshold),
        .cmp_en    (cmp_en),
        .cmp_dir   (cmp_dir),
        .irq       (irq)
    );

    assert_result_new_R5: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (result == $past(conv_data)));
endmodule

// File: tb/sim_adc_cmp_gate.sv
`timescale 1ns/1ps
module sim_adc_cmp_gate;
    localparam int LAT = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [2:0] bus_waddr = '0;
    logic [7:0] bus_wdata = '0;
    logic [2:0] bus_raddr = 3'd2;
    logic [7:0] bus_rdata;
    logic       conv_start;
    logic [2:0] conv_chan;
    logic       conv_done = 1'b0;
    logic [7:0] conv_data = '0;
    logic       irq;

    int checks = 0;
    int errors = 0;

    typedef struct { logic irq; logic [7:0] v; string tag; } sb_item_t;
    sb_item_t   sb[$];
    logic [7:0] dq[$];
    logic [2:0] chlog[$];
    logic       model_done = 1'b0;
    logic       md_prev = 1'b0;
    logic       model_busy = 1'b0;
    int         n_starts = 0;
    logic [7:0] last_v = '0;
    logic [7:0] sh_thr = '0;
    logic [7:0] sh_cmp = '0;

    always #4 clk = ~clk;

    adc_cmp_gate u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_waddr(bus_waddr),
        .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
        .conv_start(conv_start), .conv_chan(conv_chan), .conv_done(conv_done),
        .conv_data(conv_data), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic ref_irq(input logic [7:0] v);
        if (!sh_cmp[7]) return 1'b1;
        if (sh_cmp[6])  return v < sh_thr;
        return v >= sh_thr;
    endfunction

    function automatic string ref_tag();
        if (!sh_cmp[7]) return "R2";
        if (sh_cmp[6])  return "R4";
        return "R3";
    endfunction

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_waddr = a; bus_wdata = d;
        if (a == 3'd3) sh_thr = d;
        if (a == 3'd4) sh_cmp = d & 8'hC0;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [7:0] exp);
        @(negedge clk);
        bus_raddr = a;
        #1;
        chk(tag, bus_rdata, exp);
        bus_raddr = 3'd2;
    endtask

    task automatic run_batch(input logic [7:0] vals[$]);
        foreach (vals[i]) dq.push_back(vals[i]);
        wr(3'd0, 8'h80);
        while (dq.size() != 0) @(negedge clk);
        wr(3'd0, 8'h00);
        repeat (2 * (LAT + 4)) @(negedge clk);
    endtask

    // converter model: answers each start request after LAT cycles
    initial begin
        forever begin
            @(negedge clk);
            conv_done = 1'b0;
            model_done = 1'b0;
            if (conv_start) begin
                logic [7:0] v;
                model_busy = 1'b1;
                n_starts++;
                chlog.push_back(conv_chan);
                v = (dq.size() != 0) ? dq.pop_front() : 8'h00;
                repeat (LAT - 1) @(negedge clk);
                conv_data = v;
                conv_done = 1'b1;
                model_done = 1'b1;
                last_v = v;
                sb.push_back('{irq: ref_irq(v), v: v, tag: ref_tag()});
                model_busy = 1'b0;
            end
        end
    end

    always @(posedge clk) md_prev <= model_done;

    // scoreboard monitor
    always @(negedge clk) begin
        if (md_prev) begin
            if (sb.size() == 0) begin
                chk("R2 scoreboard underflow", 1, 0);
            end else begin
                sb_item_t it;
                it = sb.pop_front();
                chk({it.tag, " irq after done"}, irq, it.irq);
                chk("R5 result stored", bus_rdata, it.v);
            end
        end else if (irq && rst_n) begin
            chk("R2 irq without conversion", irq, 0);
        end
    end

    initial begin
        #(200000 * 8);
        chk("watchdog expired", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] b[$];
        int s0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9 reset state and map
        for (int a = 0; a < 8; a++) rd_chk("R9 reset value", 3'(a), 8'h00);
        chk("R9 irq reset", irq, 0);
        chk("R1 start reset", conv_start, 0);
        wr(3'd0, 8'h7F); rd_chk("R9 ctrl mask", 3'd0, 8'h00);
        wr(3'd1, 8'hFF); rd_chk("R9 chan mask", 3'd1, 8'h07);
        wr(3'd3, 8'hA5); rd_chk("R9 threshold", 3'd3, 8'hA5);
        wr(3'd4, 8'hFF); rd_chk("R9 cmp mask", 3'd4, 8'hC0);
        wr(3'd2, 8'h55); rd_chk("R9 result read-only", 3'd2, 8'h00);
        wr(3'd6, 8'hFF); rd_chk("R9 unused address", 3'd6, 8'h00);
        wr(3'd4, 8'h00); wr(3'd1, 8'h00);

        // R1 no starts while disabled
        s0 = n_starts;
        repeat (20) @(negedge clk);
        chk("R1 no start while disabled", n_starts, s0);

        // R7 stray done strobe ignored
        @(negedge clk);
        conv_data = 8'h3C; conv_done = 1'b1;
        @(negedge clk);
        chk("R7 irq on stray done", irq, 0);
        rd_chk("R7 result after stray done", 3'd2, 8'h00);

        // R2 compare disabled
        b = '{8'h10, 8'hF0, 8'h00};
        run_batch(b);

        // R3 at-or-above, threshold 0x80
        wr(3'd3, 8'h80); wr(3'd4, 8'h80);
        b = '{8'h7F, 8'h80, 8'hFF, 8'h00, 8'h81};
        run_batch(b);

        // R4 below, threshold 0x80
        wr(3'd4, 8'hC0);
        b = '{8'h7F, 8'h80, 8'h00, 8'hFF};
        run_batch(b);

        // R4 threshold 0 never matches below; R3 threshold 0 always matches
        wr(3'd3, 8'h00);
        b = '{8'h05, 8'h00};
        run_batch(b);
        wr(3'd4, 8'h80);
        b = '{8'h00, 8'hFE};
        run_batch(b);

        // R5 overwrite without read, R6 hold after stop
        wr(3'd4, 8'h00);
        b = '{8'h12, 8'h34, 8'h56};
        run_batch(b);
        rd_chk("R6 result held after stop", 3'd2, last_v);
        s0 = n_starts;
        repeat (30) @(negedge clk);
        chk("R6 no start after stop", n_starts, s0);
        rd_chk("R5 result is last conversion", 3'd2, last_v);

        // R8 channel captured at start
        chlog.delete();
        wr(3'd1, 8'h05);
        dq.push_back(8'h11); dq.push_back(8'h22);
        wr(3'd0, 8'h80);
        while (!model_busy) @(negedge clk);
        wr(3'd1, 8'h02);
        while (dq.size() != 0) @(negedge clk);
        wr(3'd0, 8'h00);
        repeat (2 * (LAT + 4)) @(negedge clk);
        chk("R8 first channel", chlog.size() >= 2, 1);
        if (chlog.size() >= 2) begin
            chk("R8 channel of first conversion", chlog[0], 3'd5);
            chk("R8 channel of next conversion", chlog[1], 3'd2);
        end
        chk("R2 scoreboard drained", sb.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule